// File: doc/BRIEF.md
# Hash Message Word Expander

This block turns one 512-bit message block into the stream of per-round words that a 64-round hash compression engine uses. After a load, it gives one pair per round. The first word of the pair is the expanded word W[j]. The second, W'[j], is that word XORed with the word four positions later in the sequence. The first sixteen words come straight from the block. Every later word is built from five earlier words with fixed rotations and the permutation P1(x) = x ^ rotl(x,15) ^ rotl(x,23).

The expanded words sit in a sixteen-word window that moves forward by one word each time the round engine accepts a pair. The newest word is computed from fixed taps of the window and shifted in at the far end. The window therefore always holds W[j] through W[j+15], and W[j+4] is on hand when round j is issued. A load fills the whole window in one cycle. The last pair is for round 63, and the valid flag then stays low until the next load.

Top module: `sm3x_expander`

## Requirements
- R1: After reset, valid_o is low and w_o and wp_o are zero.
- R2: load_i writes the sixteen block words in one cycle. Word k is block_i[511-32k -: 32], so the first byte of the block sits in bits 511:504 and each word reads big-endian. On the cycle after the load, valid_o is high and w_o equals word 0.
- R3: For j of 16 and above, the word issued for round j is P1(W[j-16] ^ W[j-9] ^ rotl(W[j-3],15)) ^ rotl(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rotl(x,15) ^ rotl(x,23) and rotl is a 32-bit left rotation.
- R4: While valid_o is high for round j, wp_o equals W[j] ^ W[j+4]. This covers rounds 60 to 63, which need W[64] to W[67].
- R5: A cycle with valid_o high and next_i high moves the outputs to the next round on the following cycle. A cycle with next_i low keeps w_o and wp_o unchanged.
- R6: Advancing past round 63 clears valid_o on the next cycle. From then until the next load, w_o and wp_o read zero.
- R7: next_i while valid_o is low has no effect: valid_o stays low and the outputs stay zero.
- R8: A load during a running sequence starts again at round 0 with the new block. It wins over a next_i in the same cycle, and the new sequence again runs a full 64 rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture block_i and restart at round 0 |
| block_i | input | 512 | Message block, first byte in the top bits |
| next_i | input | 1 | Round engine has consumed the current pair |
| w_o | output | 32 | Expanded word W[j] |
| wp_o | output | 32 | Derived word W[j] ^ W[j+4] |
| valid_o | output | 1 | A pair for rounds 0 to 63 is on the outputs |

## Verification
The bench drives several kinds of block. A fixed padded short-message block catches a wrong tap or rotation in the recurrence. An all-zero block must give all-zero words, and an all-ones block shows up any missing or extra inversion in the mixing. Random blocks with random stalls try many values at once and check that stalls hold the outputs. Directed cases cover a reload in the middle of a sequence while next_i is also high, advancing while idle, and the end after round 63. Together these separate faults in the round count from faults in the data path.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(word_t x, int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t perm_p1(word_t x);
    return x ^ rotl(x, 15) ^ rotl(x, 23);
  endfunction

  // New word from the five earlier words it depends on (distances 16,9,3,13,6)
  function automatic word_t next_word(word_t d16, word_t d9, word_t d3,
                                      word_t d13, word_t d6);
    return perm_p1(d16 ^ d9 ^ rotl(d3, 15)) ^ rotl(d13, 7) ^ d6;
  endfunction
endpackage

// File: rtl/sm3x_word_window.sv
module sm3x_word_window
  import sm3x_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [DEPTH*WORD_W-1:0]       block_i,
  input  logic                          shift_i,
  input  word_t                         fill_i,
  output logic [DEPTH-1:0][WORD_W-1:0]  win_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_o[i] <= '0;
        else if (load_i)  win_o[i] <= block_i[(DEPTH-1-i)*WORD_W +: WORD_W];
        else if (shift_i) win_o[i] <= fill_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_o[i] <= '0;
        else if (load_i)  win_o[i] <= block_i[(DEPTH-1-i)*WORD_W +: WORD_W];
        else if (shift_i) win_o[i] <= win_o[i+1];
      end
    end
  end
endmodule

// File: rtl/sm3x_word_mix.sv
module sm3x_word_mix
  import sm3x_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] win_i,
  output word_t                        fill_o
);
  // Slot DEPTH-1 holds W[j+15]; the new word is W[j+DEPTH]
  localparam int TAP_D16 = DEPTH - 16;
  localparam int TAP_D9  = DEPTH - 9;
  localparam int TAP_D3  = DEPTH - 3;
  localparam int TAP_D13 = DEPTH - 13;
  localparam int TAP_D6  = DEPTH - 6;

  always_comb begin
    fill_o = next_word(win_i[TAP_D16], win_i[TAP_D9], win_i[TAP_D3],
                       win_i[TAP_D13], win_i[TAP_D6]);
  end
endmodule

// File: rtl/sm3x_round_seq.sv
module sm3x_round_seq #(
  parameter int ROUNDS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic next_i,
  output logic valid_o,
  output logic step_o
);
  localparam int CNT_W = $clog2(ROUNDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic [CNT_W-1:0] round_q;
  logic             at_last;

  assign step_o  = valid_o && next_i && !load_i;
  assign at_last = (round_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_q <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      round_q <= '0;
      valid_o <= 1'b1;
    end else if (step_o) begin
      round_q <= at_last ? '0 : round_q + 1'b1;
      if (at_last) valid_o <= 1'b0;
    end
  end

  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_o && !at_last |=> valid_o && round_q == $past(round_q) + 1'b1); // R5
  AST_FINAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    step_o && at_last |=> !valid_o); // R6
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && !load_i |=> !valid_o); // R7
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o && round_q == '0); // R8
endmodule

// File: rtl/sm3x_expander.sv
module sm3x_expander
  import sm3x_pkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int NUM_ROUNDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [NUM_WORDS*WORD_W-1:0]   block_i,
  input  logic                          next_i,
  output logic [WORD_W-1:0]             w_o,
  output logic [WORD_W-1:0]             wp_o,
  output logic                          valid_o
);
  localparam int BLOCK_W = NUM_WORDS * WORD_W;
  localparam int LEAD    = 4;

  logic [NUM_WORDS-1:0][WORD_W-1:0] window;
  word_t fill_word;
  logic  step;

  sm3x_round_seq #(.ROUNDS(NUM_ROUNDS)) i_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .next_i(next_i),
    .valid_o(valid_o), .step_o(step)
  );

  sm3x_word_mix #(.DEPTH(NUM_WORDS)) i_mix (
    .win_i(window), .fill_o(fill_word)
  );

  sm3x_word_window #(.DEPTH(NUM_WORDS)) i_window (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
    .shift_i(step), .fill_i(fill_word), .win_o(window)
  );

  assign w_o  = valid_o ? window[0] : '0;
  assign wp_o = valid_o ? (window[0] ^ window[LEAD]) : '0;

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o && w_o == $past(block_i[BLOCK_W-1 -: WORD_W])); // R2
  AST_SHIFT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !valid_o || w_o == $past(window[1])); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !next_i && !load_i |=> $stable(w_o) && $stable(wp_o)); // R5
  AST_DROP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> w_o == '0 && wp_o == '0); // R6
endmodule

// File: tb/test_sm3x_expander.sv
module test_sm3x_expander;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         next_i = 1'b0;
  logic [31:0]  w_o, wp_o;
  logic         valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_w [0:67];

  always #4 clk = ~clk;

  sm3x_expander i_sm3x_expander (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
    .next_i(next_i), .w_o(w_o), .wp_o(wp_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] b_rol(logic [31:0] x, int n);
    logic [63:0] d;
    d = {x, x} << n;
    return d[63:32];
  endfunction

  function automatic logic [31:0] b_p1(logic [31:0] x);
    return b_rol(x, 23) ^ x ^ b_rol(x, 15);
  endfunction

  task automatic expand(input logic [511:0] blk);
    for (int k = 0; k < 16; k++) exp_w[k] = blk[511-32*k -: 32];
    for (int j = 16; j < 68; j++)
      exp_w[j] = exp_w[j-6] ^ b_rol(exp_w[j-13], 7) ^
                 b_p1(b_rol(exp_w[j-3], 15) ^ exp_w[j-9] ^ exp_w[j-16]);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [511:0] blk, input logic with_next);
    expand(blk);
    block_i = blk; load_i = 1'b1; next_i = with_next;
    tick();
    load_i = 1'b0; next_i = 1'b0;
    check("R2 valid after load", {31'd0, valid_o}, 32'd1);
    check("R2 first word", w_o, exp_w[0]);
  endtask

  // Walk rounds first..63, checking every pair, then the end of sequence
  task automatic walk(input int first, input int stall_pct);
    for (int j = first; j < 64; j++) begin
      check("R5 valid in run", {31'd0, valid_o}, 32'd1);
      check(j < 16 ? "R2 block word" : "R3 expanded word", w_o, exp_w[j]);
      check("R4 derived word", wp_o, exp_w[j] ^ exp_w[j+4]);
      if (($urandom % 100) < stall_pct) begin
        tick();
        check("R5 hold W", w_o, exp_w[j]);
        check("R5 hold W'", wp_o, exp_w[j] ^ exp_w[j+4]);
      end
      next_i = 1'b1;
      tick();
      next_i = 1'b0;
    end
    check("R6 valid low after 63", {31'd0, valid_o}, 32'd0);
    check("R6 W zero", w_o, 32'd0);
    check("R6 W' zero", wp_o, 32'd0);
    next_i = 1'b1;
    tick();
    tick();
    next_i = 1'b0;
    check("R7 idle next valid", {31'd0, valid_o}, 32'd0);
    check("R7 idle next W", w_o, 32'd0);
  endtask

  function automatic logic [511:0] rand_block();
    logic [511:0] b;
    for (int k = 0; k < 16; k++) b[32*k +: 32] = $urandom;
    return b;
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] blk_a, blk_b;
    void'($urandom(32'd1357));
    repeat (3) tick();
    check("R1 reset valid", {31'd0, valid_o}, 32'd0);
    check("R1 reset W", w_o, 32'd0);
    check("R1 reset W'", wp_o, 32'd0);
    rst_n = 1'b1;
    tick();
    next_i = 1'b1; tick(); next_i = 1'b0;
    check("R7 next before any load", {31'd0, valid_o}, 32'd0);

    // Directed: padded three-byte message block
    blk_a = '0;
    blk_a[511:480] = 32'h61626380;
    blk_a[31:0]    = 32'h00000018;
    do_load(blk_a, 1'b0);
    walk(0, 0);

    do_load('0, 1'b0);
    walk(0, 20);
    do_load({512{1'b1}}, 1'b0);
    walk(0, 20);

    for (int t = 0; t < 6; t++) begin
      do_load(rand_block(), 1'b0);
      walk(0, 30);
    end

    // R8: reload mid-sequence with next_i high in the same cycle
    blk_a = rand_block();
    blk_b = rand_block();
    do_load(blk_a, 1'b0);
    for (int j = 0; j < 10; j++) begin
      next_i = 1'b1; tick(); next_i = 1'b0;
    end
    check("R8 mid-run word", w_o, exp_w[10]);
    do_load(blk_b, 1'b1);
    check("R8 restart derived", wp_o, exp_w[0] ^ exp_w[4]);
    walk(0, 10);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule